// File: doc/BRIEF.md
# Precision Timer Prescaler with Deferred Reload

This block produces the advance strobe for a main timer counter. In fine mode an 8-bit select register sets the division ratio to its value plus one. This gives every ratio from divide-by-1 to divide-by-256. In coarse mode the select register has no effect. A 3-bit input then picks a power-of-two ratio from 1 to 128.

Software may write the select register at any time. A new value is held as pending and is not used straight away. The running period always completes under the ratio it started with. The pending value becomes active only at the edge where the prescale counter wraps back to zero, so no tick period is ever cut short or stretched. A read of the register returns the value written last, whether or not that value is active yet.

A small state machine controls the counter. It has two states, HALT and RUN, and both follow the global enable. The transition HALT to RUN occurs at a clock edge that samples the enable high. The transition RUN to HALT occurs at a clock edge that samples the enable low. While the machine is in HALT, the counter stays at zero, no tick is produced, and the pending value is copied into the active ratio on every cycle.

Top module: `tp_prescaler_top`

## Requirements
- R1: The select register is 8 bits wide and resets to 0. `rd_data` returns the value written last (`wr_en` high at a clock edge), starting in the cycle after the write, even while that value is still pending.
- R2: In fine mode (`fine_mode` = 1) with active select value S, `tick` is high once every S+1 clock cycles.
- R3: In fine mode, a select value of 0 makes `tick` high on every cycle in RUN.
- R4: In coarse mode (`fine_mode` = 0), `tick` is high once every 2^`coarse_sel` cycles (`coarse_sel` 0..7), and the select register has no effect.
- R5: A value written while the machine is in RUN does not change the ratio until the current period ends with a tick. From the next period on, the new ratio applies.
- R6: In HALT, `tick` is low and the counter is held at zero. A value written during HALT is active from the first period after RUN is entered.
- R7: `tick` is high in the cycle in which the counter equals the terminal count. The counter is zero in the cycle after a tick. For ratios above 1, each tick lasts exactly one cycle.
- R8: HALT changes to RUN at the first edge that samples `run_en` = 1. At that point the counter starts from zero, so with ratio D the first tick occurs D cycles after that edge. RUN changes to HALT at an edge that samples `run_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the select register |
| wr_data | input | 8 | Value to write into the select register |
| rd_data | output | 8 | Value written last to the select register |
| fine_mode | input | 1 | 1 selects the fine ratio, 0 selects the power-of-two ratio |
| coarse_sel | input | 3 | Power-of-two exponent used in coarse mode |
| run_en | input | 1 | Global enable |
| tick | output | 1 | One-cycle advance strobe |

## Verification
The hardest situation to reach is a write that lands part-way through a running period. In that case the active ratio and the pending ratio differ, and only the length of the periods shows which of the two is in use. The stimulus first locks onto a tick at divide-by-10. It then writes a select value of 3 two cycles later. Next it measures the distance to the following tick, which must still be 10 cycles from the last one, and then the distance to the tick after that, which must be 4 cycles. A reload that took effect straight away would give a tick almost at once.

// File: rtl/tp_pkg.sv
package tp_pkg;
    localparam int TP_SEL_W = 8;
    localparam int TP_CRS_W = 3;
    localparam int TP_CNT_W = TP_SEL_W;

    typedef enum logic [0:0] {
        TP_HALT = 1'b0,
        TP_RUN  = 1'b1
    } tp_state_e;
endpackage

// File: rtl/tp_sel_reg.sv
module tp_sel_reg #(
    parameter int SEL_W = tp_pkg::TP_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_data,
    input  logic             reload,
    output logic [SEL_W-1:0] pend_q,
    output logic [SEL_W-1:0] live_q
);
    // pending copy: always the value written last
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend_q <= '0;
        else if (wr_en) pend_q <= wr_data;
    end

    // live copy: refreshed only at a period boundary or while halted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      live_q <= '0;
        else if (reload) live_q <= pend_q;
    end

    AST_PEND_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> pend_q == $past(wr_data)); // R1
    AST_LIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(live_q)); // R5
endmodule

// File: rtl/tp_coarse_term.sv
module tp_coarse_term #(
    parameter int CRS_W = tp_pkg::TP_CRS_W,
    parameter int CNT_W = tp_pkg::TP_CNT_W
) (
    input  logic [CRS_W-1:0] exp_sel,
    output logic [CNT_W-1:0] term
);
    localparam int NUM_EXP = 1 << CRS_W;

    // terminal count 2^exp - 1: a thermometer of exp ones
    for (genvar b = 0; b < CNT_W; b++) begin : g_bit
        if (b < NUM_EXP) begin : g_live
            assign term[b] = (int'(exp_sel) > b);
        end else begin : g_zero
            assign term[b] = 1'b0;
        end
    end
endmodule

// File: rtl/tp_div_counter.sv
module tp_div_counter
    import tp_pkg::*;
#(
    parameter int CNT_W = TP_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [CNT_W-1:0] term,
    output tp_state_e        state_o,
    output logic             tick_o,
    output logic             reload_o
);
    tp_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit = (cnt_q >= term);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TP_HALT: if (run_en)  state_d = TP_RUN;
            TP_RUN:  if (!run_en) state_d = TP_HALT;
            default: state_d = TP_HALT;
        endcase
    end

    // state and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TP_HALT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == TP_HALT || state_q == TP_HALT || hit) cnt_q <= '0;
            else                                                 cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        tick_o   = 1'b0;
        reload_o = 1'b0;
        unique case (state_q)
            TP_HALT: reload_o = 1'b1;
            TP_RUN: begin
                tick_o   = hit;
                reload_o = hit;
            end
            default: reload_o = 1'b1;
        endcase
    end

    assign state_o = state_q;

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == TP_HALT |-> !tick_o); // R6
    AST_HALT_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == TP_HALT |-> cnt_q == '0); // R6
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> cnt_q == '0); // R7
    AST_ENTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TP_HALT && run_en) |=> state_q == TP_RUN); // R8
endmodule

// File: rtl/tp_prescaler_top.sv
module tp_prescaler_top
    import tp_pkg::*;
#(
    parameter int SEL_W = TP_SEL_W,
    parameter int CRS_W = TP_CRS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_data,
    output logic [SEL_W-1:0] rd_data,
    input  logic             fine_mode,
    input  logic [CRS_W-1:0] coarse_sel,
    input  logic             run_en,
    output logic             tick
);
    localparam int CNT_W = SEL_W;

    logic [SEL_W-1:0] pend, live;
    logic [CNT_W-1:0] coarse_term, term;
    logic             reload;
    tp_state_e        state;

    tp_sel_reg #(.SEL_W(SEL_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .reload(reload), .pend_q(pend), .live_q(live)
    );

    tp_coarse_term #(.CRS_W(CRS_W), .CNT_W(CNT_W)) u_crs (
        .exp_sel(coarse_sel), .term(coarse_term)
    );

    // terminal count source chosen by the mode bit
    assign term = fine_mode ? live : coarse_term;

    tp_div_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .term(term),
        .state_o(state), .tick_o(tick), .reload_o(reload)
    );

    assign rd_data = pend;

    AST_READ_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data)); // R1
    AST_RATIO_HELD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TP_RUN && !tick) |=> $stable(live)); // R5
endmodule

// File: tb/sim_tp_prescaler_top.sv
`timescale 1ns/1ps
module sim_tp_prescaler_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       fine_mode = 1'b1;
    logic [2:0] coarse_sel = '0;
    logic       run_en = 1'b0;
    logic       tick;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    tp_prescaler_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .fine_mode(fine_mode), .coarse_sel(coarse_sel),
        .run_en(run_en), .tick(tick)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_sel(input logic [7:0] v);
        wr_en = 1'b1;
        wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!tick && n < 1000);
    endtask

    // {fine, sel, coarse, expected ticks in 512 cycles}
    localparam int NV = 10;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 8'd0,   3'd0, 10'd512},
        {1'b1, 8'd1,   3'd0, 10'd256},
        {1'b1, 8'd2,   3'd5, 10'd170},
        {1'b1, 8'd4,   3'd0, 10'd102},
        {1'b1, 8'd99,  3'd0, 10'd5},
        {1'b1, 8'd255, 3'd0, 10'd2},
        {1'b0, 8'd0,   3'd0, 10'd512},
        {1'b0, 8'd5,   3'd3, 10'd64},
        {1'b0, 8'd200, 3'd7, 10'd4},
        {1'b0, 8'd0,   3'd1, 10'd256}
    };

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R1 reset select", int'(rd_data), 0);
        check("R6 reset tick", int'(tick), 0);

        for (int v = 0; v < NV; v++) begin
            run_en = 1'b0;
            step();
            fine_mode  = VEC[v][21];
            coarse_sel = VEC[v][12:10];
            write_sel(VEC[v][20:13]);
            check("R1 readback", int'(rd_data), int'(VEC[v][20:13]));
            step();
            run_en = 1'b1;
            n = 0;
            for (int c = 0; c < 512; c++) begin
                step();
                if (tick) n++;
            end
            if (VEC[v][21]) check(VEC[v][20:13] == 0 ? "R3 every cycle" : "R2 fine ratio", n, int'(VEC[v][9:0]));
            else            check("R4 coarse ratio", n, int'(VEC[v][9:0]));
        end

        // R7: single-cycle pulse at divide-by-4
        run_en = 1'b0; fine_mode = 1'b1;
        write_sel(8'd3);
        step();
        run_en = 1'b1;
        wait_tick(n);
        check("R8 first tick after enable", n, 4);
        step();
        check("R7 pulse width", int'(tick), 0);

        // R5: write part-way through a divide-by-10 period
        run_en = 1'b0;
        write_sel(8'd9);
        step();
        run_en = 1'b1;
        wait_tick(n);
        step();
        step();
        write_sel(8'd3);
        check("R1 pending readback", int'(rd_data), 3);
        wait_tick(n);
        check("R5 old ratio completes", n, 7);
        wait_tick(n);
        check("R5 new ratio applies", n, 4);

        // R6: halt silences tick; R8: restart from zero
        run_en = 1'b0;
        write_sel(8'd9);
        n = 0;
        for (int c = 0; c < 30; c++) begin
            step();
            if (tick) n++;
        end
        check("R6 no tick in halt", n, 0);
        run_en = 1'b1;
        wait_tick(n);
        check("R8 restart period", n, 10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule